// File: doc/BRIEF.md
# Prescaled Interrupt Countdown Timer

This block is the timer of a local interrupt controller. Software loads a 32-bit start value; the block counts it down once for every prescaled clock and, when the count runs out, emits a one-cycle request carrying the interrupt vector programmed in the timer's entry. The count reads back at any time through the same register port.

A divide setting picks the prescale ratio, from 1 to 128. The timer entry selects one of two modes. In one-shot mode the count stops at zero. In periodic mode it reloads the start value and keeps running. A mask bit in the entry lets the count run without ever raising a request. A controller-wide software enable guards the entry: while that enable is off, any entry write comes out masked.

Register access is a single-cycle write strobe plus a combinational read. The address selects one of five registers:

| Address | Register |
|---|---|
| 0 | Config: bit 0 is the software enable |
| 1 | Entry: bits 7:0 are the vector, bit 16 is the mask, bit 17 selects periodic mode |
| 2 | Start value |
| 3 | Current count |
| 4 | Divide |

Top module: `tmr_countdown`

## Requirements
- R1: The prescale ratio is decoded only from divide bits 3, 1 and 0, taken as the code {b3,b1,b0}. Codes 0 to 6 give ratios of 2, 4, 8, 16, 32, 64 and 128. Code 7 gives a ratio of 1. All other divide bits are ignored and read back as zero.
- R2: Writing a nonzero start value loads the current count with it and restarts the prescaler. The first expiry strobe appears at the clock edge that lies value × ratio edges after the write edge.
- R3: Writing a start value of zero halts counting. The current count keeps the value it held, and no strobe follows.
- R4: In one-shot mode (entry bit 17 = 0) the count stops at zero after expiry. It then reads 0, and no further strobe occurs until the start value is written again.
- R5: In periodic mode (entry bit 17 = 1), expiry reloads the start value. Strobes then recur every value × ratio clocks.
- R6: Each expiry with the entry mask (bit 16) clear pulses irq_valid for one cycle, with irq_vector equal to entry bits 7:0. An expiry with the mask set produces no strobe.
- R7: An entry write made while config bit 0 is clear stores the mask bit as 1, whatever value was written for it.
- R8: After reset the entry mask reads 1, the start value and the current count read 0, the software enable reads 0, and irq_valid is low.
- R9: The current-count register (address 3) is read-only: writes to it leave the value read back unchanged.
- R10: reg_rdata shows the addressed register in the same cycle. Addresses 5 to 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq_valid | output | 1 | One-cycle expiry request |
| irq_vector | output | 8 | Vector carried with the request |

## Verification
A wrong prescaler phase or a wrong reload shows up as an expiry strobe that arrives early or late. The error is visible at the first expiry after a start-value write, so every interval the bench measures is compared against value × ratio exactly. A wrong mask or mode state shows up within one period, either as a strobe that should not appear or as a count that does not settle at zero. A wrong held count shows up on the next read of the current-count register.

// File: rtl/tmr_pkg.sv
// Shared constants and helpers for the countdown timer.
// Assumes a 3-bit register address space and an 8-bit vector.
package tmr_pkg;
    localparam int RA_CFG   = 0;
    localparam int RA_ENTRY = 1;
    localparam int RA_INIT  = 2;
    localparam int RA_CUR   = 3;
    localparam int RA_DIV   = 4;

    localparam int ENTRY_MASK_BIT = 16;
    localparam int ENTRY_PER_BIT  = 17;

    // Map the compacted divide code to a power-of-two shift.
    function automatic logic [2:0] div_shift(input logic [2:0] code);
        return (code == 3'd7) ? 3'd0 : code + 3'd1;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: pulses tick once every 2**shift clocks.
// Assumes restart realigns the phase so that the first tick comes 2**shift clocks later.
module tmr_prescaler #(
    parameter int PRE_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] shift,
    output logic       tick
);
    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] limit;

    // Build the terminal value 2**shift - 1 as a mask of low ones.
    always_comb begin
        limit = '0;
        for (int i = 0; i < PRE_W; i++)
            if (i < int'(shift)) limit[i] = 1'b1;
    end

    // A greater-or-equal test keeps the phase safe when the ratio shrinks mid-count.
    assign tick = (pre_cnt >= limit);

    // Advance the phase counter, and clear it on restart or on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)                pre_cnt <= '0;
        else if (restart || tick)  pre_cnt <= '0;
        else                       pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
// Down-counter with one-shot and periodic expiry and a registered request strobe.
// Assumes load is a one-cycle write of the start value, with load_val the new value.
module tmr_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] init_q,
    input  logic             tick,
    input  logic             periodic,
    input  logic             masked,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] count,
    output logic             irq_valid,
    output logic [VEC_W-1:0] irq_vector
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic running;
    logic expire;

    assign running = (init_q != '0);
    assign expire  = running && tick && !load && (count == ONE);

    // Hold, load, decrement or reload the current count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (load) begin
            if (load_val != '0) count <= load_val;
        end else if (expire)
            count <= periodic ? init_q : '0;
        else if (running && tick && count != '0)
            count <= count - ONE;
    end

    // Register the expiry request together with its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid <= expire && !masked;
            if (expire) irq_vector <= vector;
        end
    end

    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!periodic && count == '0 && !load) |=> (count == '0)); // R4
    AST_ZERO_INIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (init_q == '0 && !load) |=> $stable(count)); // R3
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked)); // R6
endmodule

// File: rtl/tmr_regs.sv
// Register bank: config enable, timer entry, start value, divide, and the read mux.
// Assumes single-cycle writes; the current count comes from the counter and is read-only.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [DATA_W-1:0] count,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              load,
    output logic [DATA_W-1:0] init_q,
    output logic [2:0]        shift,
    output logic              periodic,
    output logic              masked,
    output logic [VEC_W-1:0]  vector
);
    logic       sw_en;
    logic [2:0] div_code;
    logic       wr_cfg, wr_entry, wr_div;

    assign wr_cfg   = reg_wr && (reg_addr == ADDR_W'(RA_CFG));
    assign wr_entry = reg_wr && (reg_addr == ADDR_W'(RA_ENTRY));
    assign wr_div   = reg_wr && (reg_addr == ADDR_W'(RA_DIV));
    assign load     = reg_wr && (reg_addr == ADDR_W'(RA_INIT));
    assign shift    = div_shift(div_code);

    // Store the control registers; an entry written while disabled comes out masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_en    <= 1'b0;
            masked   <= 1'b1;
            periodic <= 1'b0;
            vector   <= '0;
            init_q   <= '0;
            div_code <= '0;
        end else begin
            if (wr_cfg) sw_en <= reg_wdata[0];
            if (wr_entry) begin
                vector   <= reg_wdata[VEC_W-1:0];
                masked   <= reg_wdata[ENTRY_MASK_BIT] | ~sw_en;
                periodic <= reg_wdata[ENTRY_PER_BIT];
            end
            if (load)   init_q   <= reg_wdata;
            if (wr_div) div_code <= {reg_wdata[3], reg_wdata[1:0]};
        end
    end

    // Select the addressed register for reading.
    always_comb begin
        reg_rdata = '0;
        case (int'(reg_addr))
            RA_CFG:   reg_rdata[0] = sw_en;
            RA_ENTRY: begin
                reg_rdata[VEC_W-1:0]     = vector;
                reg_rdata[ENTRY_MASK_BIT] = masked;
                reg_rdata[ENTRY_PER_BIT]  = periodic;
            end
            RA_INIT:  reg_rdata = init_q;
            RA_CUR:   reg_rdata = count;
            RA_DIV:   reg_rdata[3:0] = {div_code[2], 1'b0, div_code[1:0]};
            default:  reg_rdata = '0;
        endcase
    end

    AST_FORCED_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_entry && !sw_en) |=> masked); // R7
endmodule

// File: rtl/tmr_countdown.sv
// Top of the interrupt countdown timer: registers, prescaler and counter.
// Assumes one clock domain and synchronous active-low reset.
module tmr_countdown #(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    localparam int PRE_W = 7;

    logic             load, tick, periodic, masked;
    logic [2:0]       shift;
    logic [CNT_W-1:0] init_q, count;
    logic [VEC_W-1:0] vector;

    tmr_regs #(.ADDR_W(ADDR_W), .DATA_W(CNT_W), .VEC_W(VEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .count(count), .reg_rdata(reg_rdata),
        .load(load), .init_q(init_q), .shift(shift), .periodic(periodic),
        .masked(masked), .vector(vector)
    );

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .restart(load), .shift(shift), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(reg_wdata),
        .init_q(init_q), .tick(tick), .periodic(periodic), .masked(masked),
        .vector(vector), .count(count), .irq_valid(irq_valid),
        .irq_vector(irq_vector)
    );
endmodule

// File: tb/test_tmr_countdown.sv
`timescale 1ns/1ps
module test_tmr_countdown;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tmr_countdown i_tmr_countdown (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic int ratio(input logic [31:0] d);
        case ({d[3], d[1], d[0]})
            3'd0: return 2;   3'd1: return 4;  3'd2: return 8;  3'd3: return 16;
            3'd4: return 32;  3'd5: return 64; 3'd6: return 128;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] entry(input logic [7:0] v, input logic m, input logic p);
        return {14'd0, p, m, 8'd0, v};
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    // Count negedges until irq_valid is seen, up to max.
    task automatic wait_irq(input int max, output int n, output bit got);
        got = 0; n = 0;
        for (int k = 0; k < max; k++) begin
            @(negedge clk);
            n++;
            if (irq_valid) begin got = 1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d, d2;
        int n; bit got;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 reset state
        rd(1, d); chk(d[16] == 1'b1, "R8 entry mask", d[16], 1);
        rd(2, d); chk(d == 0, "R8 start value", d, 0);
        rd(3, d); chk(d == 0, "R8 count", d, 0);
        rd(0, d); chk(d == 0, "R8 enable", d, 0);
        chk(irq_valid == 0, "R8 irq", irq_valid, 0);

        // R7 forced mask while disabled
        wr(1, entry(8'h40, 1'b0, 1'b0));
        rd(1, d); chk(d[16] == 1'b1, "R7 mask forced", d[16], 1);
        wr(0, 32'd1);
        wr(1, entry(8'h40, 1'b0, 1'b0));
        rd(1, d); chk(d[16] == 1'b0, "R7 mask clear when enabled", d[16], 0);

        // R10 unused addresses
        rd(6, d); chk(d == 0, "R10 unused address", d, 0);

        // R1 every divide code, with junk in ignored bits
        for (int c = 0; c < 8; c++) begin
            logic [31:0] dv;
            dv = {$urandom} & ~32'hB;
            dv = dv | {28'd0, c[2], 1'b0, c[1:0]};
            wr(4, dv);
            rd(4, d); chk(d == (dv & 32'hB), "R1 divide readback", d, dv & 32'hB);
            wr(1, entry(8'(8'h50 + c), 1'b0, 1'b0));
            wr(2, 32'd3);
            wait_irq(3 * 128 + 10, n, got);
            chk(got && n == 3 * ratio(dv), "R1 R2 expiry time", n, 3 * ratio(dv));
            chk(irq_vector == 8'(8'h50 + c), "R6 vector", irq_vector, 8'h50 + c);
        end

        // R4 one-shot stays at zero
        rd(3, d); chk(d == 0, "R4 count at zero", d, 0);
        wait_irq(400, n, got); chk(!got, "R4 no refire", got, 0);
        rd(3, d); chk(d == 0, "R4 count held", d, 0);

        // R5 periodic recurrence
        wr(4, 32'h0000_0001);                 // ratio 4
        wr(1, entry(8'h77, 1'b0, 1'b1));
        wr(2, 32'd5);
        for (int k = 0; k < 3; k++) begin
            wait_irq(100, n, got);
            chk(got && n == 20, "R5 period", n, 20);
        end

        // R6 masked expiry is silent
        wr(4, 32'h0000_000B);                 // ratio 1
        wr(1, entry(8'h77, 1'b1, 1'b1));
        wr(2, 32'd5);
        wait_irq(40, n, got); chk(!got, "R6 masked silent", got, 0);
        rd(3, d); chk(d >= 1 && d <= 5, "R5 periodic count range", d, 5);

        // R2 restart on rewrite
        wr(1, entry(8'h21, 1'b0, 1'b0));
        wr(2, 32'd100);
        repeat (50) @(negedge clk);
        wr(2, 32'd10);
        wait_irq(200, n, got); chk(got && n == 10, "R2 restart", n, 10);

        // R3 zero start value halts
        wr(2, 32'd1000);
        repeat (20) @(negedge clk);
        wr(2, 32'd0);
        rd(3, d);
        repeat (10) @(negedge clk);
        rd(3, d2); chk(d == d2 && d != 0, "R3 count held", d2, d);
        wait_irq(1100, n, got); chk(!got, "R3 no strobe", got, 0);

        // R9 count is read-only
        wr(3, 32'h1234);
        rd(3, d2); chk(d2 == d, "R9 write ignored", d2, d);

        // Random one-shot runs
        for (int k = 0; k < 20; k++) begin
            logic [31:0] dv; logic [7:0] v; int nv;
            dv = {$urandom}; v = 8'($urandom); nv = 1 + int'($urandom % 15);
            wr(4, dv);
            wr(1, entry(v, 1'b0, 1'b0));
            wr(2, 32'(nv));
            wait_irq(nv * 128 + 10, n, got);
            chk(got && n == nv * ratio(dv), "R2 random expiry", n, nv * ratio(dv));
            chk(irq_vector == v, "R6 random vector", irq_vector, v);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule